// File: doc/BRIEF.md
# Synchronized Slot Byte Injector

This block places one byte onto a shared, pulled-up serial line. It does not start frames of its own. Another device on the line opens each frame with a low start bit. Once the block is armed, it waits for that start bit, lets one bit period go by, and then sends eight data bits. It sends a 0 by pulling the line low and a 1 by leaving the line released. It can only overwrite a byte in which the owner of the frame leaves the line high for the whole byte, which is an all-ones byte. That is how a controller joins a stream that another device clocks.

The line is sensed through a synchronizer, and a start bit is recognised only on a falling edge of the synchronized level. A single parameter gives the bit period in clock cycles. That same count sets both the delay after the start bit and the length of each data bit, so any timing error stays a whole number of clocks. Receivers sample near mid-bit, so this error must stay well below half a bit. The block releases the line after the eighth bit and signals the release with a one-clock done pulse.

Top module: `slot_injector`

## Requirements
- R1: While reset is asserted and after it is released, `drive_low` is 0 and `done` is 0.
- R2: An `arm` pulse seen while the block is idle captures `tx_byte` on that clock edge. Later changes of `tx_byte` do not affect the bits that are sent.
- R3: While armed, a start is a high-to-low change of `bus_in` after a synchronizer of SYNC_STAGES (default 2) flops. Let E0 be the first rising clock edge that samples `bus_in` low. With the default synchronizer, the first data bit appears on `drive_low` right after edge E0+BIT_CYCLES+2.
- R4: `drive_low` stays 0 for the whole bit period that follows a detected start bit.
- R5: Eight data bits go out least significant bit first, each lasting BIT_CYCLES clocks. `drive_low` is 1 exactly when the current bit is 0.
- R6: At the edge that ends the eighth bit, `drive_low` returns to 0 and `done` is 1 for exactly one clock.
- R7: An `arm` pulse while the block is armed or injecting is ignored. This includes the last clock of the eighth bit. An `arm` pulse in the clock where `done` is high is accepted.
- R8: A falling edge of the line while the block is not armed produces no drive and no `done`.
- R9: Arming while the line is already low does not count as a start. Injection waits for the line to rise and then fall again.
- R10: An all-ones byte leaves `drive_low` at 0 through the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Sensed level of the shared line, asynchronous |
| tx_byte | input | DATA_BITS | Byte to inject, captured on arm |
| arm | input | 1 | One-clock request to inject the next frame |
| drive_low | output | 1 | 1 turns on the pull-down of the line |
| done | output | 1 | One-clock pulse when the line is released |

## Verification
Two events can land on the same clock: the arm strobe for the next frame and the end of the current frame. The bench raises `arm` across the edge that closes the eighth bit. It then shows at the ports that the request was dropped, because a later start bit draws no drive. It also raises `arm` in the clock where `done` is high, carrying a new byte. The next frame must then carry that new byte bit for bit.

// File: rtl/inj_pkg.sv
package inj_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_LEAD  = 2'd2,
      ST_DATA  = 2'd3
   } inj_state_e;
endpackage

// File: rtl/inj_bus_sync.sv
module inj_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_s,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("inj_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= line_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b1;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign line_s = chain_q[STAGES-1];
   assign fall   = prev_q & ~line_s;
endmodule

// File: rtl/inj_bit_timer.sv
module inj_bit_timer #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   generate
      if (PERIOD < 4) begin : g_bad_period
         $error("inj_bit_timer: PERIOD must be at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/inj_shifter.sv
module inj_shifter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] data_in,
   input  logic             shift,
   output logic             bit_out,
   output logic             last
);
   localparam int NW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [NW-1:0] LAST_IDX = NW'(WIDTH - 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("inj_shifter: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sh_q;
   logic [NW-1:0]    idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '1;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= data_in;
         idx_q <= '0;
      end else if (shift) begin
         sh_q  <= {1'b1, sh_q[WIDTH-1:1]};
         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
   end

   assign bit_out = sh_q[0];
   assign last    = (idx_q == LAST_IDX);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(sh_q));
   a_r5_load_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));
endmodule

// File: rtl/slot_injector.sv
module slot_injector #(
   parameter int BIT_CYCLES  = 5208,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_in,
   input  logic [DATA_BITS-1:0] tx_byte,
   input  logic                 arm,
   output logic                 drive_low,
   output logic                 done
);
   import inj_pkg::*;

   inj_state_e state_q, state_d;
   logic       line_s, fall, tick, bit_out, last_bit;
   logic       run, load, shift, done_d, done_q;

   inj_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .line_in(bus_in), .line_s(line_s), .fall(fall)
   );

   inj_bit_timer #(.PERIOD(BIT_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   inj_shifter #(.WIDTH(DATA_BITS)) i_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .data_in(tx_byte),
      .shift(shift), .bit_out(bit_out), .last(last_bit)
   );

   assign run   = (state_q == ST_LEAD) || (state_q == ST_DATA);
   assign load  = (state_q == ST_IDLE) && arm;
   assign shift = (state_q == ST_DATA) && tick;

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      case (state_q)
         ST_IDLE:  if (arm)  state_d = ST_ARMED;
         ST_ARMED: if (fall) state_d = ST_LEAD;
         ST_LEAD:  if (tick) state_d = ST_DATA;
         ST_DATA:  if (tick && last_bit) begin
                      state_d = ST_IDLE;
                      done_d  = 1'b1;
                   end
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
      end
   end

   assign drive_low = (state_q == ST_DATA) && !bit_out;
   assign done      = done_q;

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !drive_low);
   a_r4_quiet_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LEAD) |-> !drive_low);
   a_r5_drive_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |-> (state_q == ST_DATA));
   a_r3_lead_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_LEAD) |-> ($past(state_q) == ST_ARMED));
   a_r7_busy_arm: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_DATA) && arm && !tick) |=> (state_q == ST_DATA));
endmodule

// File: tb/test_slot_injector.sv
module test_slot_injector;
   localparam int CLK_PERIOD = 10;
   localparam int BITP = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       other_low = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       arm = 1'b0;
   logic       drive_low, done, bus_in;
   int         errors = 0;
   int         checks = 0;

   assign bus_in = ~(other_low | drive_low);

   always #(CLK_PERIOD/2) clk = ~clk;

   slot_injector #(.BIT_CYCLES(BITP), .DATA_BITS(8), .SYNC_STAGES(2)) i_slot_injector (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .tx_byte(tx_byte),
      .arm(arm), .drive_low(drive_low), .done(done)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R2: captured on the arm edge, then tx_byte is scrambled
   task automatic do_arm(input logic [7:0] b);
      @(negedge clk); arm = 1'b1; tx_byte = b;
      @(negedge clk); arm = 1'b0; tx_byte = ~b;
   endtask

   task automatic check_frame(input logic [7:0] exp, input int mid_arm_bit,
                              input logic late_arm, input logic done_arm,
                              input logic [7:0] done_val);
      int rem;
      @(negedge clk); other_low = 1'b1;
      repeat (3) @(posedge clk);
      repeat (BITP/2) @(posedge clk);
      @(negedge clk);
      check(drive_low == 1'b0, "R4 lead quiet", drive_low, 0);
      other_low = 1'b0;
      repeat (BITP - BITP/2) @(posedge clk);
      for (int i = 0; i < 8; i++) begin
         rem = BITP - BITP/2;
         repeat (BITP/2) @(posedge clk);
         @(negedge clk);
         check(drive_low == ~exp[i], "R2/R5/R10 data bit", drive_low, ~exp[i]);
         if (i == mid_arm_bit) begin
            arm = 1'b1; tx_byte = 8'h5A;
            @(negedge clk); arm = 1'b0;
            rem = rem - 1;
         end
         if (i == 7 && late_arm) begin
            repeat (rem - 1) @(posedge clk);
            @(negedge clk); arm = 1'b1; tx_byte = 8'hC3;
            @(posedge clk);
         end else begin
            repeat (rem) @(posedge clk);
         end
      end
      @(negedge clk);
      arm = 1'b0;
      check(done == 1'b1 && drive_low == 1'b0, "R6 release", {done, drive_low}, 2);
      if (done_arm) begin arm = 1'b1; tx_byte = done_val; end
      @(negedge clk);
      check(done == 1'b0, "R6 done width", done, 0);
      if (done_arm) begin arm = 1'b0; tx_byte = ~done_val; end
   endtask

   task automatic pulse_and_watch(input int n, input string req);
      logic bad = 1'b0;
      @(negedge clk); other_low = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == BITP) other_low = 1'b0;
         if (drive_low || done) bad = 1'b1;
      end
      other_low = 1'b0;
      check(!bad, req, bad, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(drive_low == 1'b0 && done == 1'b0, "R1 in reset", {drive_low, done}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(drive_low == 1'b0 && done == 1'b0, "R1 after reset", {drive_low, done}, 0);
   endtask

   task automatic t_lead_timing;
      int n = 0;
      do_arm(8'h00);
      @(negedge clk); other_low = 1'b1;
      while (!drive_low && n < 4*BITP) begin
         @(posedge clk); n++;
         @(negedge clk);
      end
      other_low = 1'b0;
      check(n == BITP + 3, "R3 first bit edge", n, BITP + 3);
      repeat (9*BITP) @(negedge clk);
   endtask

   task automatic t_basic;
      do_arm(8'hA5);
      check_frame(8'hA5, -1, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic t_all_ones;
      do_arm(8'hFF);
      check_frame(8'hFF, -1, 1'b0, 1'b0, 8'h00);   // R10
   endtask

   task automatic t_busy_arm;
      do_arm(8'h3C);
      check_frame(8'h3C, 3, 1'b0, 1'b1, 8'h81);   // R7 mid arm ignored, done arm taken
      check_frame(8'h81, -1, 1'b1, 1'b0, 8'h00);  // R7 arm at last edge ignored
      repeat (4) @(negedge clk);
      pulse_and_watch(12*BITP, "R7 late arm dropped");
   endtask

   task automatic t_unarmed;
      pulse_and_watch(12*BITP, "R8 unarmed fall");
   endtask

   task automatic t_arm_low;
      logic bad = 1'b0;
      @(negedge clk); other_low = 1'b1;
      repeat (4) @(negedge clk);
      do_arm(8'h0F);
      for (int i = 0; i < 2*BITP; i++) begin
         @(negedge clk);
         if (drive_low || done) bad = 1'b1;
      end
      check(!bad, "R9 armed while low", bad, 0);
      other_low = 1'b0;
      repeat (4) @(negedge clk);
      check_frame(8'h0F, -1, 1'b0, 1'b0, 8'h00);  // R9 next fall starts it
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_lead_timing();
      t_basic();
      t_all_ones();
      t_busy_arm();
      t_unarmed();
      t_arm_low();
      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule